// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a byte program or a sector/bulk erase that is already under way has finished, and whether it worked. A start request loads the byte address to watch, the kind of operation (program or erase), the byte that was programmed, and the detection method. The method is either completion-bit polling on bit 7 or toggle detection on bit 6. The engine then reads the device over a simple request/acknowledge port until it can give a verdict.

The engine checks every apparent completion with one more read of the whole byte. When the device raises its error flag (bit 5), the engine does not give up at once. It reads again, because the completion bit may have changed in the same cycle as the error flag. If the result is a failure, the engine writes the reset command byte to the device before it reports. A read-count watchdog stops a device that never settles.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `mem_req_o`, `done_o`, `pass_o`, `fail_o` and `timeout_o` are all 0.
- R2: Bit-7 polling of a program compares read bit 7 with bit 7 of the programmed byte. On a mismatch with bit 5 clear, it reads again. On a match, it makes one confirming read and passes if that read equals the programmed byte.
- R3: For an erase, the expected bit 7 is 1 and the confirming read must return FFh.
- R4: In bit-7 polling, a mismatch with bit 5 set causes exactly one further read. The engine goes on to the confirming read if bit 7 of that read matches, and fails otherwise.
- R5: In toggle mode, the first read is only a reference. Each later read is compared on bit 6 with the read before it. Equal bit 6 leads to the confirming read. Unequal bit 6 with bit 5 clear means another read.
- R6: In toggle mode, unequal bit 6 with bit 5 set causes two more reads. If bit 6 is equal in those two reads, the engine goes on to the confirming read. If not, it fails.
- R7: Every read of a job uses the address loaded at start and has `mem_we_o` = 0.
- R8: After any failure, the engine issues exactly one write of F0h to the job address before `done_o`. A passing job issues no write.
- R9: A confirming read that differs from the expected byte gives a failure.
- R10: If the device still gives no decision when read number MAX_READS returns, the job fails with `timeout_o` = 1.
- R11: `done_o` is high for exactly one cycle, and exactly one of `pass_o`/`fail_o` is high at that time. The verdict stays unchanged until the next accepted start.
- R12: A start pulse while `busy_o` is high is ignored and does not change the job address or the outcome.
- R13: While `mem_req_o` is high and not acknowledged, the request, address, write flag and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a job (taken only when idle) |
| start_addr_i | input | AW | Byte address to watch |
| start_erase_i | input | 1 | 1 = erase job, 0 = program job |
| start_data_i | input | 8 | Byte that was programmed |
| start_toggle_i | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 polling |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write access |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Job succeeded |
| fail_o | output | 1 | Job failed |
| timeout_o | output | 1 | Failure was caused by the watchdog |

## Verification
A wrong phase register shows up as a read count that differs from the count the read script predicts. It also shows up as a missing or extra F0h write, and both appear at the port within one acknowledged access of the mistake. A stale bit-6 reference or a wrong expected byte flips `pass_o`/`fail_o` at the `done_o` pulse, which is a few cycles after the deciding read. A bad watchdog threshold changes the number of reads before a timeout by at least one. Address or handshake mistakes are caught on the cycle the request is raised.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
   localparam int DW       = 8;
   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;
   localparam int ERR_BIT  = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_RSTWR,
      ST_FINISH
   } fpe_state_e;

   typedef enum logic [2:0] {
      PH_POLL,
      PH_RECHK,
      PH_TG_FIRST,
      PH_TG_RUN,
      PH_TG_X1,
      PH_TG_X2,
      PH_CONFIRM
   } fpe_phase_e;

   typedef enum logic [1:0] {
      V_STALL,
      V_STEP,
      V_PASS,
      V_FAIL
   } fpe_verdict_e;
endpackage

// File: rtl/fpe_judge.sv
module fpe_judge
   import fpe_pkg::*;
(
   input  fpe_phase_e        phase_i,
   input  logic [DW-1:0]     rdata_i,
   input  logic              prev_tog_i,
   input  logic [DW-1:0]     exp_byte_i,
   output fpe_verdict_e      verdict_o,
   output fpe_phase_e        nxt_phase_o
);
   logic bit_ok;
   logic tog_same;
   logic err_seen;

   assign bit_ok   = (rdata_i[POLL_BIT] == exp_byte_i[POLL_BIT]);
   assign tog_same = (rdata_i[TOG_BIT] == prev_tog_i);
   assign err_seen = rdata_i[ERR_BIT];

   always_comb begin
      verdict_o   = V_STALL;
      nxt_phase_o = phase_i;
      unique case (phase_i)
         PH_POLL: begin
            if (bit_ok) begin
               verdict_o   = V_STEP;
               nxt_phase_o = PH_CONFIRM;
            end else if (err_seen) begin
               verdict_o   = V_STEP;
               nxt_phase_o = PH_RECHK;
            end
         end
         PH_RECHK: begin
            verdict_o   = bit_ok ? V_STEP : V_FAIL;
            nxt_phase_o = PH_CONFIRM;
         end
         PH_TG_FIRST: begin
            verdict_o   = V_STALL;
            nxt_phase_o = PH_TG_RUN;
         end
         PH_TG_RUN: begin
            if (tog_same) begin
               verdict_o   = V_STEP;
               nxt_phase_o = PH_CONFIRM;
            end else if (err_seen) begin
               verdict_o   = V_STEP;
               nxt_phase_o = PH_TG_X1;
            end
         end
         PH_TG_X1: begin
            verdict_o   = V_STEP;
            nxt_phase_o = PH_TG_X2;
         end
         PH_TG_X2: begin
            verdict_o   = tog_same ? V_STEP : V_FAIL;
            nxt_phase_o = PH_CONFIRM;
         end
         PH_CONFIRM: begin
            verdict_o   = (rdata_i == exp_byte_i) ? V_PASS : V_FAIL;
            nxt_phase_o = PH_CONFIRM;
         end
         default: begin
            verdict_o   = V_FAIL;
            nxt_phase_o = PH_POLL;
         end
      endcase
   end
endmodule

// File: rtl/fpe_watchdog.sv
module fpe_watchdog #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic expired_o
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expired_o = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
               cnt_q <= '0;
            end else if (tick_i && cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expired_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
   import fpe_pkg::*;
#(
   parameter int           AW         = 19,
   parameter int           MAX_READS  = 1024,
   parameter logic [7:0]   RESET_CODE = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] start_addr_i,
   input  logic          start_erase_i,
   input  logic [7:0]    start_data_i,
   input  logic          start_toggle_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic [7:0]    mem_rdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o,
   output logic          timeout_o
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("flash_poll_engine: AW must be at least 1");
      end
      if (MAX_READS < 0) begin : g_bad_lim
         $error("flash_poll_engine: MAX_READS must not be negative");
      end
      if (DW != 8) begin : g_bad_dw
         $error("flash_poll_engine: byte-wide device expected");
      end
   endgenerate

   fpe_state_e    state_q;
   fpe_phase_e    phase_q;
   fpe_phase_e    nxt_phase;
   fpe_verdict_e  verdict;
   logic [AW-1:0] addr_q;
   logic [7:0]    exp_q;
   logic          prev_tog_q;
   logic          wd_expired;
   logic          accept;
   logic          rd_ack;

   assign accept = (state_q == ST_IDLE) && start_i;
   assign rd_ack = (state_q == ST_READ) && mem_ack_i;

   fpe_judge u_judge (
      .phase_i     (phase_q),
      .rdata_i     (mem_rdata_i),
      .prev_tog_i  (prev_tog_q),
      .exp_byte_i  (exp_q),
      .verdict_o   (verdict),
      .nxt_phase_o (nxt_phase)
   );

   fpe_watchdog #(.LIMIT(MAX_READS)) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (accept),
      .tick_i    (rd_ack),
      .expired_o (wd_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_POLL;
         addr_q     <= '0;
         exp_q      <= '0;
         prev_tog_q <= 1'b0;
         pass_o     <= 1'b0;
         fail_o     <= 1'b0;
         timeout_o  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  addr_q    <= start_addr_i;
                  exp_q     <= start_erase_i ? 8'hFF : start_data_i;
                  phase_q   <= start_toggle_i ? PH_TG_FIRST : PH_POLL;
                  pass_o    <= 1'b0;
                  fail_o    <= 1'b0;
                  timeout_o <= 1'b0;
                  state_q   <= ST_READ;
               end
            end
            ST_READ: begin
               if (mem_ack_i) begin
                  prev_tog_q <= mem_rdata_i[TOG_BIT];
                  unique case (verdict)
                     V_STALL: begin
                        if (wd_expired) begin
                           fail_o    <= 1'b1;
                           timeout_o <= 1'b1;
                           state_q   <= ST_RSTWR;
                        end else begin
                           phase_q <= nxt_phase;
                        end
                     end
                     V_STEP: phase_q <= nxt_phase;
                     V_PASS: begin
                        pass_o  <= 1'b1;
                        state_q <= ST_FINISH;
                     end
                     default: begin
                        fail_o  <= 1'b1;
                        state_q <= ST_RSTWR;
                     end
                  endcase
               end
            end
            ST_RSTWR: begin
               if (mem_ack_i) begin
                  state_q <= ST_FINISH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_RSTWR);
   assign mem_we_o    = (state_q == ST_RSTWR);
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = (state_q == ST_RSTWR) ? RESET_CODE : 8'h00;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_FINISH);
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
   parameter int AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [AW-1:0] start_addr_i,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [7:0]    mem_wdata_o,
   input logic          mem_ack_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic          fail_o,
   input logic          timeout_o
);
   logic [AW-1:0] job_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         job_addr <= '0;
      end else if (start_i && !busy_o) begin
         job_addr <= start_addr_i;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !done_o));

   a_r7_job_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o == job_addr));

   a_r8_reset_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_wdata_o == 8'hF0 && fail_o && !pass_o));

   a_r10_timeout_fail: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> fail_o);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o ^ fail_o));

   a_r11_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

   a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind flash_poll_engine fpe_checker #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .start_addr_i (start_addr_i),
   .mem_req_o    (mem_req_o),
   .mem_we_o     (mem_we_o),
   .mem_addr_o   (mem_addr_o),
   .mem_wdata_o  (mem_wdata_o),
   .mem_ack_i    (mem_ack_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .pass_o       (pass_o),
   .fail_o       (fail_o),
   .timeout_o    (timeout_o)
);

// File: tb/flash_poll_engine_tb.sv
module flash_poll_engine_tb_top;
   localparam int AW  = 19;
   localparam int LIM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic          start_erase_i = 1'b0;
   logic [7:0]    start_data_i = 8'h00;
   logic          start_toggle_i = 1'b0;
   logic          mem_req_o, mem_we_o;
   logic [AW-1:0] mem_addr_o;
   logic [7:0]    mem_wdata_o;
   logic          mem_ack_i = 1'b0;
   logic [7:0]    mem_rdata_i = 8'h00;
   logic          busy_o, done_o, pass_o, fail_o, timeout_o;

   int total = 0;
   int bad = 0;

   logic [7:0]    resp [0:5];
   int            resp_n = 1;
   int            idx = 0;
   int            rd_cnt = 0;
   int            wr_cnt = 0;
   int            addr_bad = 0;
   logic [7:0]    last_wdata = 8'h00;
   logic [AW-1:0] exp_addr = '0;

   always #5 clk = ~clk;

   flash_poll_engine #(.AW(AW), .MAX_READS(LIM)) dut_i (.*);

   // Device stand-in: acknowledges every other cycle, plays a read script.
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack_i <= 1'b0;
      end else begin
         if (start_i && !busy_o) idx <= 0;
         if (mem_ack_i) begin
            mem_ack_i <= 1'b0;
         end else if (mem_req_o) begin
            mem_ack_i <= 1'b1;
            if (mem_addr_o != exp_addr) addr_bad <= addr_bad + 1;
            if (mem_we_o) begin
               wr_cnt     <= wr_cnt + 1;
               last_wdata <= mem_wdata_o;
            end else begin
               mem_rdata_i <= resp[idx];
               if (idx < resp_n - 1) idx <= idx + 1;
               rd_cnt <= rd_cnt + 1;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] a, b, c, d, e, f, input int n);
      resp[0] = a; resp[1] = b; resp[2] = c;
      resp[3] = d; resp[4] = e; resp[5] = f;
      resp_n = n;
   endtask

   int rd0, wr0, ab0;

   task automatic launch(input logic [AW-1:0] a, input logic er,
                         input logic [7:0] d, input logic tg);
      rd0 = rd_cnt; wr0 = wr_cnt; ab0 = addr_bad;
      exp_addr = a;
      @(negedge clk);
      start_i = 1'b1; start_addr_i = a; start_erase_i = er;
      start_data_i = d; start_toggle_i = tg;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_job(input string req);
      int n = 0;
      while (!done_o && n < 500) begin
         @(negedge clk);
         n++;
      end
      check({req, " done seen"}, int'(done_o), 1);
      @(negedge clk);
      check("R11 done one cycle", int'(done_o), 0);
   endtask

   task automatic expect_out(input string req, input int p, input int reads,
                             input int writes, input int to);
      check({req, " pass"}, int'(pass_o), p);
      check({req, " fail"}, int'(fail_o), 1 - p);
      check({req, " reads"}, rd_cnt - rd0, reads);
      check({req, " R8 writes"}, wr_cnt - wr0, writes);
      check({req, " timeout"}, int'(timeout_o), to);
      check("R7 address", addr_bad - ab0, 0);
      if (writes != 0) check("R8 reset byte", int'(last_wdata), 8'hF0);
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy_o), 0);
      check("R1 req", int'(mem_req_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 pass", int'(pass_o), 0);
      check("R1 fail", int'(fail_o), 0);
      check("R1 timeout", int'(timeout_o), 0);
   endtask

   task automatic t_poll_program();
      load(8'h05, 8'h05, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 4);
      launch(19'h12345, 1'b0, 8'hA5, 1'b0);
      finish_job("R2");
      expect_out("R2", 1, 4, 0, 0);
      repeat (5) @(negedge clk);
      check("R11 pass held", int'(pass_o), 1);
   endtask

   task automatic t_poll_erase();
      load(8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 3);
      launch(19'h40010, 1'b1, 8'h00, 1'b0);
      finish_job("R3");
      expect_out("R3", 1, 4, 0, 0);
   endtask

   task automatic t_erase_confirm_bad();
      load(8'hFF, 8'hFE, 8'hFE, 8'hFE, 8'hFE, 8'hFE, 2);
      launch(19'h50000, 1'b1, 8'h00, 1'b0);
      finish_job("R9");
      expect_out("R9", 0, 2, 1, 0);
   endtask

   task automatic t_err_recheck_pass();
      load(8'h20, 8'hA0, 8'h80, 8'h80, 8'h80, 8'h80, 3);
      launch(19'h00777, 1'b0, 8'h80, 1'b0);
      finish_job("R4");
      expect_out("R4 pass", 1, 3, 0, 0);
   endtask

   task automatic t_err_recheck_fail();
      load(8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 1);
      launch(19'h00778, 1'b0, 8'h80, 1'b0);
      finish_job("R4");
      expect_out("R4 fail", 0, 2, 1, 0);
   endtask

   task automatic t_toggle_pass();
      load(8'h40, 8'h00, 8'h00, 8'h3C, 8'h3C, 8'h3C, 4);
      launch(19'h21000, 1'b0, 8'h3C, 1'b1);
      finish_job("R5");
      expect_out("R5", 1, 4, 0, 0);
   endtask

   task automatic t_toggle_err_pass();
      load(8'h00, 8'h60, 8'h40, 8'h40, 8'h3C, 8'h3C, 5);
      launch(19'h21001, 1'b0, 8'h3C, 1'b1);
      finish_job("R6");
      expect_out("R6 pass", 1, 5, 0, 0);
   endtask

   task automatic t_toggle_err_fail();
      load(8'h00, 8'h60, 8'h40, 8'h00, 8'h00, 8'h00, 4);
      launch(19'h21002, 1'b0, 8'h3C, 1'b1);
      finish_job("R6");
      expect_out("R6 fail", 0, 4, 1, 0);
   endtask

   task automatic t_timeout();
      load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1);
      launch(19'h33333, 1'b0, 8'h80, 1'b0);
      finish_job("R10");
      expect_out("R10", 0, LIM, 1, 1);
   endtask

   task automatic t_busy_start();
      load(8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 6);
      launch(19'h0ABCD, 1'b0, 8'h80, 1'b0);
      @(negedge clk);
      start_i = 1'b1; start_addr_i = 19'h7FFFF; start_data_i = 8'h00;
      @(negedge clk);
      start_i = 1'b0;
      finish_job("R12");
      expect_out("R12", 1, 6, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_poll_program();
      t_poll_erase();
      t_erase_confirm_bad();
      t_err_recheck_pass();
      t_err_recheck_fail();
      t_toggle_pass();
      t_toggle_err_pass();
      t_toggle_err_fail();
      t_timeout();
      t_busy_start();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule